// File: doc/BRIEF.md
# I2C Target Port with Status Flags

This block is the target (slave) side of an I2C bus, with a small register port for software. It watches the open-drain SCL and SDA lines through a synchronizer. When a START is followed by an address byte, it compares the byte against a programmed 7-bit address, or against the general-call address if that is enabled. On a match it acknowledges. It then moves bytes between the bus and one data register. Received bytes are read from that register, and bytes to be transmitted are written to it.

Events are recorded in a status register. Each event has a matching bit in an interrupt-enable register, and the interrupt line is the OR of the status bits whose enable bit is set. Each bit of the status register is cleared by writing 0 to it. Software paces the traffic: at every byte boundary the target holds SCL low until the data register has been serviced. Writes to a receiving target always start with one dummy read of the data register.

The register port is plain: one-cycle `reg_wr` and `reg_rd` strobes on an offset, with combinational read data. There is no valid/ready stream at the edge. Back-pressure toward the bus master comes only from holding SCL low.

Top module: `i2c_tgt_port`

## Requirements
- R1: After reset every register (CTRL offset 0, ADDR offset 1, STAT offset 2, IEN offset 3, DATA offset 4) reads 0, and `irq`, `sda_oe` and `scl_oe` are 0.
- R2: With the interface enabled, an address byte whose upper 7 bits equal ADDR[6:0] is acknowledged (SDA low in the ninth clock) and sets STAT bit 0. Any other address is not acknowledged and sets no flag.
- R3: With CTRL bit 1 set, the address byte 0x00 is acknowledged and sets STAT bits 6 and 0. With CTRL bit 1 clear, 0x00 is not acknowledged.
- R4: STAT bit 5 takes the R/W bit (bit 0) of each matched address byte; 1 means the target transmits.
- R5: After a matched write address, SCL is held low once the acknowledge clock ends, until DATA has been read once (the dummy read).
- R6: A received data byte is acknowledged, appears at DATA and sets STAT bit 1. SCL is then held low after the acknowledge clock until DATA is read.
- R7: While CTRL bit 0 is set, every received data byte is answered with NACK but is still stored and flagged. The bit stays set until software clears it, and address bytes are still acknowledged.
- R8: After a matched read address, SCL is held low until DATA is written. That byte is then shifted out MSB first. STAT bit 3 is set when the byte is loaded into the shifter, and STAT bit 2 is set in the master's acknowledge clock.
- R9: A NACK from the master after a transmitted byte ends the transfer: the target drives neither SDA nor SCL until the next START.
- R10: A STOP sets STAT bit 4 only if the target was addressed since the last START.
- R11: Writing STAT clears each bit 0-4 and bit 6 whose written value is 0, and leaves bits written as 1 unchanged. STAT bit 5 ignores writes.
- R12: `irq` is 1 exactly when some STAT bit and the same IEN bit are both 1.
- R13: With CTRL bit 2 (interface enable) clear, the target acknowledges nothing, raises no flag and releases both lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (byte-boundary hold) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a DATA read frees the receive buffer) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt: OR of STAT AND IEN |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer and a 3-bit register offset. The bus master model runs with a 200 ns half period, which gives the synchronizer and edge detectors about 20 clocks per SCL phase. That spacing lets the bench sample SDA and the hold state in a known cycle. Because the model's lines are wired-AND with the target's enables, every SCL hold actually blocks the master, so each dummy read, data read and data write the bench performs is what releases the bus. The default depth also leaves room for the extra synchronizer cycle to be absorbed inside one SCL phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int TADDR_W = 7;
  localparam int STAT_W = 7;

  // register offsets
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_ADDR = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_IEN  = 3'd3;
  localparam logic [2:0] OFS_DATA = 3'd4;

  // control bits
  localparam int CB_FNA = 0;
  localparam int CB_GC  = 1;
  localparam int CB_EN  = 2;

  // status bits
  localparam int SB_ADR  = 0;
  localparam int SB_RX   = 1;
  localparam int SB_TXD  = 2;
  localparam int SB_EMP  = 3;
  localparam int SB_STOP = 4;
  localparam int SB_TXM  = 5;
  localparam int SB_GC   = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX_WAIT, ST_RX, ST_RX_ACK,
    ST_TX_WAIT, ST_TX, ST_TX_ACK
  } tgt_state_t;

  typedef struct packed {
    logic addr;
    logic rw;
    logic gc;
    logic rx;
    logic txload;
    logic txdone;
    logic stop;
  } tgt_ev_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q[0] <= scl_i;
      sda_q[0] <= sda_i;
      for (int k = 1; k < STAGES; k++) begin
        scl_q[k] <= scl_q[k-1];
        sda_q[k] <= sda_q[k-1];
      end
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edges while SCL stays high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic                sda_s,
  input  logic                en,
  input  logic                gc_en,
  input  logic                fna,
  input  logic [TADDR_W-1:0]  own_addr,
  input  logic                rx_free,
  input  logic                tx_ready,
  input  logic [BYTE_W-1:0]   tx_byte,
  output logic                sda_oe,
  output logic                scl_oe,
  output tgt_ev_t             ev,
  output logic [BYTE_W-1:0]   rx_byte
);
  localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

  tgt_state_t        st;
  logic [BYTE_W-1:0] sh;
  logic [2:0]        cnt;
  logic              full, sel, rw, ackd;
  logic              hit_own, hit_gc;

  assign hit_own = (sh[BYTE_W-1:1] == own_addr);
  assign hit_gc  = gc_en && (sh == '0);
  assign rx_byte = sh;
  assign scl_oe  = ((st == ST_RX_WAIT) && !rx_free) ||
                   ((st == ST_TX_WAIT) && !tx_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; sh <= '0; cnt <= '0; full <= 1'b0;
      sel <= 1'b0; rw <= 1'b0; ackd <= 1'b0; sda_oe <= 1'b0; ev <= '0;
    end else begin
      ev <= '0;
      if (!en) begin
        st <= ST_IDLE; sda_oe <= 1'b0; sel <= 1'b0;
      end else if (start_det) begin
        st <= ST_ADDR; cnt <= '0; full <= 1'b0; sda_oe <= 1'b0; sel <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0; ev.stop <= sel; sel <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              sh <= {sh[BYTE_W-2:0], sda_s};
              if (cnt == LAST_BIT) full <= 1'b1;
              else cnt <= cnt + 3'd1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              if (st == ST_RX) begin
                ev.rx  <= 1'b1;
                sda_oe <= !fna;
                st     <= ST_RX_ACK;
              end else if (hit_own || hit_gc) begin
                sda_oe  <= 1'b1;
                sel     <= 1'b1;
                rw      <= sh[0];
                ev.addr <= 1'b1;
                ev.rw   <= sh[0];
                ev.gc   <= hit_gc;
                st      <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= rw ? ST_TX_WAIT : ST_RX_WAIT;
          end
          ST_RX_WAIT: if (rx_free) begin
            st <= ST_RX; cnt <= '0; full <= 1'b0;
          end
          ST_RX_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_RX_WAIT;
          end
          ST_TX_WAIT: if (tx_ready) begin
            sh        <= tx_byte;
            sda_oe    <= !tx_byte[BYTE_W-1];
            ev.txload <= 1'b1;
            cnt       <= '0;
            full      <= 1'b0;
            st        <= ST_TX;
          end
          ST_TX: begin
            if (scl_rise) begin
              if (cnt == LAST_BIT) full <= 1'b1;
              else cnt <= cnt + 3'd1;
            end else if (scl_fall) begin
              if (full) begin
                full   <= 1'b0;
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe <= !sh[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              ackd      <= !sda_s;
              ev.txdone <= 1'b1;
            end else if (scl_fall) begin
              st <= ackd ? ST_TX_WAIT : ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [BYTE_W-1:0]  reg_wdata,
  output logic [BYTE_W-1:0]  reg_rdata,
  output logic               irq,
  input  tgt_ev_t            ev,
  input  logic [BYTE_W-1:0]  rx_byte,
  output logic               ctrl_en,
  output logic               ctrl_gc,
  output logic               ctrl_fna,
  output logic [TADDR_W-1:0] own_addr,
  output logic               rx_free,
  output logic               tx_ready,
  output logic [BYTE_W-1:0]  tx_byte,
  output logic [STAT_W-1:0]  stat,
  output logic [STAT_W-1:0]  ien
);
  logic [STAT_W-1:0] stat_nx, stat_set;
  logic [BYTE_W-1:0] rx_q;
  logic              wr_stat, wr_data, rd_data;

  assign wr_stat = reg_wr && (reg_addr == REG_AW'(OFS_STAT));
  assign wr_data = reg_wr && (reg_addr == REG_AW'(OFS_DATA));
  assign rd_data = reg_rd && (reg_addr == REG_AW'(OFS_DATA));

  always_comb begin
    stat_set          = '0;
    stat_set[SB_ADR]  = ev.addr;
    stat_set[SB_RX]   = ev.rx;
    stat_set[SB_TXD]  = ev.txdone;
    stat_set[SB_EMP]  = ev.txload;
    stat_set[SB_STOP] = ev.stop;
    stat_set[SB_GC]   = ev.addr && ev.gc;
  end

  for (genvar g = 0; g < STAT_W; g++) begin : g_stat
    if (g == SB_TXM) begin : g_mode
      assign stat_nx[g] = ev.addr ? ev.rw : stat[g];
    end else begin : g_flag
      assign stat_nx[g] = stat_set[g] | (stat[g] & ~(wr_stat & ~reg_wdata[g]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0; ctrl_gc <= 1'b0; ctrl_fna <= 1'b0;
      own_addr <= '0; ien <= '0; stat <= '0; rx_q <= '0;
      tx_byte <= '0; tx_ready <= 1'b0; rx_free <= 1'b1;
    end else begin
      stat <= stat_nx;
      if (reg_wr && reg_addr == REG_AW'(OFS_CTRL)) begin
        ctrl_en  <= reg_wdata[CB_EN];
        ctrl_gc  <= reg_wdata[CB_GC];
        ctrl_fna <= reg_wdata[CB_FNA];
      end
      if (reg_wr && reg_addr == REG_AW'(OFS_ADDR)) own_addr <= reg_wdata[TADDR_W-1:0];
      if (reg_wr && reg_addr == REG_AW'(OFS_IEN))  ien <= reg_wdata[STAT_W-1:0];
      if (ev.rx) rx_q <= rx_byte;
      if (ev.rx || (ev.addr && !ev.rw)) rx_free <= 1'b0;
      else if (rd_data)                 rx_free <= 1'b1;
      if (ev.txload) tx_ready <= 1'b0;
      else if (wr_data) begin
        tx_ready <= 1'b1;
        tx_byte  <= reg_wdata;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      REG_AW'(OFS_CTRL): reg_rdata = {5'd0, ctrl_en, ctrl_gc, ctrl_fna};
      REG_AW'(OFS_ADDR): reg_rdata = {1'b0, own_addr};
      REG_AW'(OFS_STAT): reg_rdata = {1'b0, stat};
      REG_AW'(OFS_IEN):  reg_rdata = {1'b0, ien};
      REG_AW'(OFS_DATA): reg_rdata = rx_q;
      default:           reg_rdata = '0;
    endcase
  end

  assign irq = |(stat & ien);
endmodule

// File: rtl/i2c_tgt_port.sv
module i2c_tgt_port
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ctrl_en, ctrl_gc, ctrl_fna, rx_free, tx_ready;
  logic [TADDR_W-1:0] own_addr;
  logic [BYTE_W-1:0]  tx_byte, rx_byte;
  logic [STAT_W-1:0]  stat, ien;
  tgt_ev_t            ev;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2c_tgt_engine u_eng (
    .clk, .rst_n, .scl_rise, .scl_fall, .start_det, .stop_det, .sda_s,
    .en(ctrl_en), .gc_en(ctrl_gc), .fna(ctrl_fna), .own_addr,
    .rx_free, .tx_ready, .tx_byte, .sda_oe, .scl_oe, .ev, .rx_byte
  );

  i2c_tgt_regs #(.REG_AW(REG_AW)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .ev, .rx_byte, .ctrl_en, .ctrl_gc, .ctrl_fna, .own_addr,
    .rx_free, .tx_ready, .tx_byte, .stat, .ien
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              sda_oe,
  input logic              scl_oe,
  input logic              scl_s,
  input logic              ctrl_en,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] ien,
  input tgt_ev_t           ev
);
  p_irq_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0));

  p_hold_when_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_s);

  p_zero_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_AW'(OFS_STAT) && !reg_wdata[SB_STOP] && !ev.stop)
      |=> !stat[SB_STOP]);

  p_one_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == REG_AW'(OFS_STAT) && reg_wdata[SB_ADR] && stat[SB_ADR])
      |=> stat[SB_ADR]);

  p_off_releases_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (!sda_oe && !scl_oe));

  p_match_acks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[SB_ADR]) |-> sda_oe);
endmodule

bind i2c_tgt_port i2c_tgt_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .scl_s(scl_s), .ctrl_en(ctrl_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .stat(stat), .ien(ien), .ev(ev)
);

// File: tb/i2c_tgt_port_tb.sv
`timescale 1ns/1ps
module i2c_tgt_port_tb;
  localparam int Q = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe, irq;
  wire  scl_line = scl_m & ~scl_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  i2c_tgt_port u_dut (
    .clk, .rst_n, .scl_i(scl_line), .sda_i(sda_line), .scl_oe, .sda_oe,
    .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata, .irq
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; scl_m = 1'b1; wait (scl_line); #Q;
    sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic m_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; wait (scl_line); #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic m_wbit(input logic b);
    sda_m = b; #Q; scl_m = 1'b1; wait (scl_line); #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic m_rbit(output logic b);
    sda_m = 1'b1; #Q; scl_m = 1'b1; wait (scl_line); #(Q/2);
    b = sda_line; #(Q/2); scl_m = 1'b0; #Q;
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(nack);
  endtask

  task automatic m_rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_rbit(d[i]);
    m_wbit(nack);
  endtask

  logic [7:0] v;
  logic       nk;

  task automatic t_reset();
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 register reset", v, 0);
    end
    chk("R1 irq reset", irq, 0);
    chk("R1 line enables reset", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_mismatch();
    m_start(); m_wbyte(8'h52, nk);
    chk("R2 foreign address not acked", nk, 1);
    m_stop();
    rd(3'd2, v); chk("R10 no stop flag when not addressed", v, 8'h00);
  endtask

  task automatic t_write();
    m_start(); m_wbyte(8'h78, nk);
    chk("R2 own address acked", nk, 0);
    rd(3'd2, v); chk("R2 R4 address flag, receive mode", v, 8'h01);
    chk("R5 SCL held before dummy read", scl_oe, 1);
    rd(3'd4, v);
    chk("R5 SCL released after dummy read", scl_oe, 0);
    m_wbyte(8'h96, nk);
    chk("R6 data byte acked", nk, 0);
    chk("R6 SCL held until data read", scl_oe, 1);
    rd(3'd4, v); chk("R6 received byte", v, 8'h96);
    m_stop();
    rd(3'd2, v); chk("R10 R6 stop and rx flags", v, 8'h13);
  endtask

  task automatic t_clear_irq();
    chk("R12 irq off with no enables", irq, 0);
    wr(3'd3, 8'h10); chk("R12 irq from enabled stop flag", irq, 1);
    wr(3'd3, 8'h20); chk("R12 irq off when enabled bit is 0", irq, 0);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R11 ones leave status", v, 8'h13);
    wr(3'd2, 8'hEE); rd(3'd2, v); chk("R11 zeros clear bits 0 and 4", v, 8'h02);
    wr(3'd2, 8'h00); rd(3'd2, v); chk("R11 all cleared", v, 8'h00);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_fna();
    wr(3'd0, 8'h05);
    m_start(); m_wbyte(8'h78, nk);
    chk("R7 address still acked", nk, 0);
    rd(3'd4, v);
    m_wbyte(8'h5A, nk); chk("R7 first byte nacked", nk, 1);
    rd(3'd4, v); chk("R7 nacked byte stored", v, 8'h5A);
    m_wbyte(8'h11, nk); chk("R7 forced NACK is sticky", nk, 1);
    rd(3'd4, v);
    wr(3'd0, 8'h04);
    m_wbyte(8'h22, nk); chk("R7 ack after clearing", nk, 0);
    rd(3'd4, v); chk("R6 byte after clearing", v, 8'h22);
    m_stop();
    wr(3'd2, 8'h00);
  endtask

  task automatic t_read();
    m_start(); m_wbyte(8'h79, nk);
    chk("R2 read address acked", nk, 0);
    rd(3'd2, v); chk("R4 transmit mode set", v, 8'h21);
    chk("R8 SCL held until data written", scl_oe, 1);
    wr(3'd4, 8'hC3);
    rd(3'd2, v); chk("R8 empty flag on load", v, 8'h29);
    m_rbyte(1'b0, v); chk("R8 first byte MSB first", v, 8'hC3);
    rd(3'd2, v); chk("R8 transmitted flag", v, 8'h2D);
    chk("R8 SCL held for next byte", scl_oe, 1);
    wr(3'd4, 8'h3A);
    m_rbyte(1'b1, v); chk("R8 second byte", v, 8'h3A);
    chk("R9 lines released after NACK", {scl_oe, sda_oe}, 0);
    m_stop();
    rd(3'd2, v); chk("R10 stop after read", v, 8'h3D);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_gc();
    m_start(); m_wbyte(8'h00, nk);
    chk("R3 general call ignored when off", nk, 1);
    m_stop();
    wr(3'd0, 8'h06);
    m_start(); m_wbyte(8'h00, nk);
    chk("R3 general call acked", nk, 0);
    rd(3'd2, v); chk("R3 general call flags", v, 8'h41);
    rd(3'd4, v); m_stop();
    wr(3'd2, 8'h00);
  endtask

  task automatic t_disabled();
    wr(3'd0, 8'h00);
    m_start(); m_wbyte(8'h78, nk);
    chk("R13 no ack when disabled", nk, 1);
    m_stop();
    rd(3'd2, v); chk("R13 no flags when disabled", v, 8'h00);
    chk("R13 lines released", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    wr(3'd1, 8'h3C);
    wr(3'd0, 8'h04);
    t_mismatch();
    t_write();
    t_clear_irq();
    t_fna();
    t_read();
    t_gc();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule